// File: doc/BRIEF.md
# Masked Ternary Search Table

This block is a small ternary lookup table. Each location holds a data word, a per-location care mask and a valid bit. A search presents a comparand. The block compares it against every valid location in parallel and reports the lowest-numbered location that matches. It also raises a flag when more than one location matches.

A bit position takes part in the comparison only when two masks both hold a 1 there: the location's own mask, and one of eight global mask registers. The search picks that global mask register with a selector. Two comparand registers, one even and one odd, hold the last key loaded into each. A search can either load its key into one of them, or reuse the key already stored there.

Each search is accepted on one clock edge and its result is registered on the next. Table and mask writes are ordered strictly against searches. A search sees every write accepted on an earlier edge and no write accepted on the same edge or later.

Top module: `tern_lookup`

## Requirements
- R1: After synchronous reset, all locations are invalid, every global mask register holds all ones, both comparand registers hold zero, and `rsp_vld`, `rsp_hit`, `rsp_multi` and `rsp_idx` are 0. `srch_rdy` is 1 from the first clock edge after reset is released.
- R2: A search accepted on edge E (`srch_req` and `srch_rdy` both high) produces `rsp_vld` = 1 for exactly the cycle after edge E+1. In cycles without a result, `rsp_vld`, `rsp_hit` and `rsp_multi` are 0 and `rsp_idx` is 0.
- R3: A location matches when, for every bit position whose location-mask bit is 1 and whose selected global-mask bit is 1, the key bit equals the stored data bit. A 0 in the location mask makes that bit a don't-care.
- R4: `gm_wr_en` writes `gm_wr_data` into global mask register `gm_wr_sel`. `srch_gsel` picks which of the eight registers applies to a search, and a 0 bit in it excludes that position from the comparison.
- R5: When several locations match, `rsp_idx` is the lowest matching location number.
- R6: `rsp_multi` is 1 when two or more locations match and 0 when only one matches. It is never 1 without `rsp_hit`.
- R7: A write with `wr_valid` = 0 invalidates the location, and an invalid location never matches. With no match, `rsp_hit` = 0 and `rsp_idx` = 0.
- R8: `srch_sel` = 0 selects the even comparand register and 1 selects the odd one. With `srch_reuse` = 0 the search uses `srch_key` and stores it in the selected register. With `srch_reuse` = 1 the search uses the value stored in the selected register, ignores `srch_key`, and leaves the register unchanged.
- R9: A location write or global mask write accepted on the same edge as a search, or later, does not affect that search. The search does see writes accepted on earlier edges.
- R10: Searches may be accepted on consecutive edges. Each produces its own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Location write strobe |
| wr_addr | input | 6 | Location to write |
| wr_data | input | 68 | Data word for the location |
| wr_mask | input | 68 | Care mask for the location (1 = compare) |
| wr_valid | input | 1 | Valid bit written with the location |
| gm_wr_en | input | 1 | Global mask write strobe |
| gm_wr_sel | input | 3 | Global mask register to write |
| gm_wr_data | input | 68 | Global mask value (1 = compare) |
| srch_req | input | 1 | Search request |
| srch_rdy | output | 1 | Block can accept a search |
| srch_key | input | 68 | Search comparand |
| srch_gsel | input | 3 | Global mask register used by this search |
| srch_sel | input | 1 | Comparand register: 0 even, 1 odd |
| srch_reuse | input | 1 | 1 = use stored comparand instead of srch_key |
| rsp_vld | output | 1 | Result valid |
| rsp_hit | output | 1 | At least one location matched |
| rsp_idx | output | 6 | Lowest matching location |
| rsp_multi | output | 1 | Two or more locations matched |

## Verification
The assertions check the response framing on every cycle. Each accepted search yields a valid result two edges later, and no result appears without one. They also check the flag relations: multi-match implies a hit, a miss reports index 0, and hit and multi-match stay clear while no result is valid. Only the bench scenarios can show whether the reported location is correct. That covers the ternary and global-mask rules, lowest-index priority, the comparand reuse behaviour and the ordering of writes against searches, because all of these depend on table contents that the assertions cannot see.

// File: rtl/tern_pkg.sv
package tern_pkg;
    parameter int unsigned TERN_WIDTH   = 68;
    parameter int unsigned TERN_DEPTH   = 64;
    parameter int unsigned TERN_GM_NUM  = 8;

    typedef enum logic {
        CMP_EVEN = 1'b0,
        CMP_ODD  = 1'b1
    } cmp_sel_e;

    typedef struct packed {
        logic hit;
        logic multi;
    } rsp_flags_t;

    function automatic logic bit_care(input logic entry_m, input logic glob_m);
        return entry_m & glob_m;
    endfunction
endpackage

// File: rtl/tern_gmask_bank.sv
module tern_gmask_bank #(
    parameter int unsigned W   = tern_pkg::TERN_WIDTH,
    parameter int unsigned NUM = tern_pkg::TERN_GM_NUM
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [$clog2(NUM)-1:0] wr_sel,
    input  logic [W-1:0]           wr_data,
    input  logic [$clog2(NUM)-1:0] rd_sel,
    output logic [W-1:0]           rd_mask
);
    localparam int unsigned SW = $clog2(NUM);

    logic [W-1:0] gm_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                gm_q[g] <= '1;
            end else if (wr_en && (wr_sel == SW'(g))) begin
                gm_q[g] <= wr_data;
            end
        end
    end

    assign rd_mask = gm_q[rd_sel];
endmodule

// File: rtl/tern_table.sv
module tern_table #(
    parameter int unsigned W     = tern_pkg::TERN_WIDTH,
    parameter int unsigned DEPTH = tern_pkg::TERN_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic [W-1:0]             wr_mask,
    input  logic                     wr_valid,
    input  logic [W-1:0]             cmp_key,
    input  logic [W-1:0]             cmp_gmask,
    output logic [DEPTH-1:0]         match_vec
);
    localparam int unsigned AW = $clog2(DEPTH);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic         vld_q;
        logic [W-1:0] dat_q;
        logic [W-1:0] msk_q;
        logic [W-1:0] care;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                dat_q <= '0;
                msk_q <= '0;
            end else if (wr_en && (wr_addr == AW'(e))) begin
                vld_q <= wr_valid;
                dat_q <= wr_data;
                msk_q <= wr_mask;
            end
        end

        always_comb begin
            for (int b = 0; b < W; b++) begin
                care[b] = tern_pkg::bit_care(msk_q[b], cmp_gmask[b]);
            end
        end

        assign match_vec[e] = vld_q && (((cmp_key ^ dat_q) & care) == '0);
    end
endmodule

// File: rtl/tern_prio.sv
module tern_prio #(
    parameter int unsigned DEPTH = tern_pkg::TERN_DEPTH
) (
    input  logic [DEPTH-1:0]         vec,
    output tern_pkg::rsp_flags_t     flags,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int unsigned AW = $clog2(DEPTH);

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = AW'(i);
            end
        end
    end

    assign flags.hit   = |vec;
    assign flags.multi = |(vec & (vec - DEPTH'(1)));
endmodule

// File: rtl/tern_lookup.sv
module tern_lookup #(
    parameter int unsigned W     = tern_pkg::TERN_WIDTH,
    parameter int unsigned DEPTH = tern_pkg::TERN_DEPTH,
    parameter int unsigned GMNUM = tern_pkg::TERN_GM_NUM
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic [W-1:0]             wr_mask,
    input  logic                     wr_valid,
    input  logic                     gm_wr_en,
    input  logic [$clog2(GMNUM)-1:0] gm_wr_sel,
    input  logic [W-1:0]             gm_wr_data,
    input  logic                     srch_req,
    output logic                     srch_rdy,
    input  logic [W-1:0]             srch_key,
    input  logic [$clog2(GMNUM)-1:0] srch_gsel,
    input  logic                     srch_sel,
    input  logic                     srch_reuse,
    output logic                     rsp_vld,
    output logic                     rsp_hit,
    output logic [$clog2(DEPTH)-1:0] rsp_idx,
    output logic                     rsp_multi
);
    import tern_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);

    logic [W-1:0]     cmp_q [2];
    logic [W-1:0]     key_eff;
    logic [W-1:0]     gmask;
    logic [DEPTH-1:0] match_now;
    logic [DEPTH-1:0] match_q;
    logic             s1_vld;
    logic             rdy_q;
    logic             accept;
    cmp_sel_e         sel;
    rsp_flags_t       flags;
    logic [AW-1:0]    win_idx;

    assign sel     = cmp_sel_e'(srch_sel);
    assign accept  = srch_req && rdy_q;
    assign key_eff = srch_reuse ? cmp_q[sel] : srch_key;

    tern_gmask_bank #(.W(W), .NUM(GMNUM)) u_gm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (gm_wr_en),
        .wr_sel  (gm_wr_sel),
        .wr_data (gm_wr_data),
        .rd_sel  (srch_gsel),
        .rd_mask (gmask)
    );

    tern_table #(.W(W), .DEPTH(DEPTH)) u_tab (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .wr_valid  (wr_valid),
        .cmp_key   (key_eff),
        .cmp_gmask (gmask),
        .match_vec (match_now)
    );

    // Stage 1: capture the match vector, so later writes cannot reach this search.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q    <= 1'b0;
            s1_vld   <= 1'b0;
            match_q  <= '0;
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
        end else begin
            rdy_q  <= 1'b1;
            s1_vld <= accept;
            if (accept) begin
                match_q <= match_now;
                if (!srch_reuse) begin
                    cmp_q[sel] <= srch_key;
                end
            end
        end
    end

    tern_prio #(.DEPTH(DEPTH)) u_prio (
        .vec   (match_q),
        .flags (flags),
        .idx   (win_idx)
    );

    // Stage 2: registered response.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_idx   <= '0;
        end else begin
            rsp_vld   <= s1_vld;
            rsp_hit   <= s1_vld && flags.hit;
            rsp_multi <= s1_vld && flags.multi;
            rsp_idx   <= (s1_vld && flags.hit) ? win_idx : '0;
        end
    end

    assign srch_rdy = rdy_q;
endmodule

// File: rtl/tern_lookup_chk.sv
module tern_lookup_chk #(
    parameter int unsigned DEPTH = tern_pkg::TERN_DEPTH
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     srch_req,
    input logic                     srch_rdy,
    input logic                     rsp_vld,
    input logic                     rsp_hit,
    input logic [$clog2(DEPTH)-1:0] rsp_idx,
    input logic                     rsp_multi
);
    logic acc;
    assign acc = srch_req && srch_rdy;

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        acc |=> ##1 rsp_vld);

    assert_resp_has_source_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> $past(acc, 2));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !rsp_vld |-> (!rsp_hit && !rsp_multi));

    assert_multi_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> rsp_hit);

    assert_miss_idx_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_idx == '0));
endmodule

bind tern_lookup tern_lookup_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tern_lookup_test.sv
module tern_lookup_test;
    localparam int W = 68;
    localparam int DEPTH = 64;
    localparam int GMN = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, wr_valid = 0, gm_wr_en = 0;
    logic [5:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0, wr_mask = '0, gm_wr_data = '0, srch_key = '0;
    logic [2:0]    gm_wr_sel = '0, srch_gsel = '0;
    logic          srch_req = 0, srch_sel = 0, srch_reuse = 0;
    logic          srch_rdy, rsp_vld, rsp_hit, rsp_multi;
    logic [5:0]    rsp_idx;

    always #10 clk = ~clk;

    tern_lookup uut (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_tag = "R1";

    typedef struct {
        int    due;
        bit    hit;
        int    idx;
        bit    multi;
        string tag;
    } exp_t;
    exp_t q[$];

    logic [W-1:0] m_dat [DEPTH];
    logic [W-1:0] m_msk [DEPTH];
    bit           m_vld [DEPTH];
    logic [W-1:0] m_gm  [GMN];
    logic [W-1:0] m_cmp [2];
    bit           rdy_seen = 0;

    function automatic void model_search(input logic [W-1:0] key, input logic [W-1:0] g,
                                         output bit hit, output int idx, output bit multi);
        int n = 0;
        idx = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i] && (((key ^ m_dat[i]) & m_msk[i] & g) == '0)) begin
                if (n == 0) idx = i;
                n++;
            end
        end
        hit = (n > 0);
        multi = (n > 1);
    endfunction

    // Reference model updated on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            q.delete();
            for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_dat[i] = '0; m_msk[i] = '0; end
            for (int i = 0; i < GMN; i++) m_gm[i] = '1;
            m_cmp[0] = '0; m_cmp[1] = '0;
        end else begin
            cyc++;
            if (srch_req && rdy_seen) begin
                exp_t e;
                logic [W-1:0] k;
                k = srch_reuse ? m_cmp[srch_sel] : srch_key;
                model_search(k, m_gm[srch_gsel], e.hit, e.idx, e.multi);
                e.due = cyc + 1;
                e.tag = cur_tag;
                q.push_back(e);
                if (!srch_reuse) m_cmp[srch_sel] = srch_key;
            end
            if (wr_en) begin
                m_vld[wr_addr] = wr_valid; m_dat[wr_addr] = wr_data; m_msk[wr_addr] = wr_mask;
            end
            if (gm_wr_en) m_gm[gm_wr_sel] = gm_wr_data;
        end
    end

    // Compare on every falling edge (slightly after it).
    always @(negedge clk) begin
        #1;
        rdy_seen = srch_rdy;
        if (!rst) begin
            bit eh, em; int ei; bit ev; string t;
            ev = 0; eh = 0; em = 0; ei = 0; t = "R2";
            if (q.size() > 0 && q[0].due == cyc) begin
                ev = 1; eh = q[0].hit; ei = q[0].idx; em = q[0].multi; t = q[0].tag;
                void'(q.pop_front());
            end
            checks++;
            if (rsp_vld !== ev || rsp_hit !== eh || rsp_multi !== em || rsp_idx !== 6'(ei)) begin
                failures++;
                $display("FAIL %s cyc=%0d actual vld=%0d hit=%0d idx=%0d multi=%0d expected vld=%0d hit=%0d idx=%0d multi=%0d",
                         t, cyc, rsp_vld, rsp_hit, rsp_idx, rsp_multi, ev, eh, ei, em);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        wr_en = 0; gm_wr_en = 0; srch_req = 0; srch_reuse = 0;
    endtask

    task automatic put(input int a, input logic [W-1:0] d, input logic [W-1:0] m, input bit v);
        wr_en = 1; wr_addr = 6'(a); wr_data = d; wr_mask = m; wr_valid = v;
    endtask

    task automatic look(input logic [W-1:0] k, input int g, input bit s, input bit r);
        srch_req = 1; srch_key = k; srch_gsel = 3'(g); srch_sel = s; srch_reuse = r;
    endtask

    task automatic gmw(input int s, input logic [W-1:0] d);
        gm_wr_en = 1; gm_wr_sel = 3'(s); gm_wr_data = d;
    endtask

    localparam logic [W-1:0] KA = 68'h9_1234_5678_9ABC_DEF0;
    localparam logic [W-1:0] KB = 68'h3_0F0F_AAAA_5555_1200;
    localparam logic [W-1:0] KC = 68'hC_DEAD_BEEF_0000_7777;
    localparam logic [W-1:0] KD = 68'h0_0000_0000_0000_0001;

    function automatic logic [W-1:0] rnd();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #2;
        checks++;
        if (srch_rdy !== 1'b1 || rsp_vld !== 1'b0) begin
            failures++;
            $display("FAIL R1 actual rdy=%0d vld=%0d expected rdy=1 vld=0", srch_rdy, rsp_vld);
        end
        @(negedge clk);
        cur_tag = "R1"; look(KA, 7, 0, 0); step();       // empty table misses
        cur_tag = "R3";
        put(5, KA, '1, 1); step();
        look(KA, 0, 0, 0); step();                        // exact hit at 5
        look(KA ^ 68'h100, 0, 0, 0); step();              // one bit off misses
        put(9, KB, ~68'hFF, 1); step();
        look(KB ^ 68'h5A, 0, 0, 0); step();               // don't-care low byte hits 9
        cur_tag = "R4";
        gmw(3, ~(68'h1 << 67)); step();
        look(KA ^ (68'h1 << 67), 3, 0, 0); step();        // bit 67 masked globally
        look(KA ^ (68'h1 << 67), 0, 0, 0); step();        // other mask: miss
        cur_tag = "R5";
        put(40, KC, '1, 1); step();
        put(20, KC, '1, 1); step();
        put(10, KC, '1, 1); step();
        look(KC, 0, 0, 0); step();                        // lowest = 10, multi
        cur_tag = "R6";
        put(10, KC, '1, 0); step();
        look(KC, 0, 0, 0); step();                        // 20, multi
        cur_tag = "R7";
        put(20, '0, '0, 0); step();
        look(KC, 0, 0, 0); step();                        // 40 alone
        cur_tag = "R5";
        put(0, KD, '1, 1); step();
        put(63, KD, '1, 1); step();
        look(KD, 0, 0, 0); step();                        // 0 wins over 63
        cur_tag = "R6";
        put(0, KD, '1, 0); step();
        look(KD, 0, 1, 0); step();                        // 63 single, odd <- KD
        cur_tag = "R8";
        look(KA, 0, 0, 0); step();                        // even <- KA
        look(KC, 0, 1, 1); step();                        // reuse odd: KD -> 63
        look(KB, 0, 0, 1); step();                        // reuse even: KA -> 5
        look(KC, 0, 1, 1); step();                        // odd still KD
        cur_tag = "R9";
        look(KA, 0, 0, 0); put(5, KA, '1, 0); step();     // same-edge invalidate unseen
        look(KA, 0, 0, 0); step();                        // now miss
        look(KA ^ (68'h1 << 66), 2, 0, 0); gmw(2, ~(68'h1 << 66)); put(5, KA, '1, 1); step();
        look(KA ^ (68'h1 << 66), 2, 0, 0); step();        // both writes seen now
        cur_tag = "R10";
        for (int i = 0; i < 8; i++) begin
            look((i % 2 == 0) ? KC : KD, 0, i % 2, 0); step();
        end
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] base;
            int pick = $urandom_range(0, 3);
            base = (pick == 0) ? KA : (pick == 1) ? KB : (pick == 2) ? KC : KD;
            if ($urandom_range(0, 2) == 0)
                put($urandom_range(0, DEPTH - 1), base, rnd() | ~68'hFF, $urandom_range(0, 4) != 0);
            if ($urandom_range(0, 9) == 0) gmw($urandom_range(0, GMN - 1), rnd() | ~68'hFFFF);
            if ($urandom_range(0, 3) != 0)
                look(base ^ (68'h1 << $urandom_range(0, 15)), $urandom_range(0, GMN - 1),
                     1'($urandom_range(0, 1)), $urandom_range(0, 4) == 0);
            step();
        end
        repeat (4) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule